// File: doc/BRIEF.md
# SIMD Address Generation Unit

This block turns one decoded instruction into the addresses needed by a control unit and a row of processing elements that share a banked memory. The instruction supplies an opcode, a per-element index select bit, two control-unit index register numbers and an address field. The control unit sees every memory bank as one flat address space. The low-order bits of a flat address pick the bank, and the remaining bits pick the word inside it. Each processing element reaches only its own bank, so it receives just a word offset.

The block holds two kinds of state. The first is a small file of control-unit index registers, whose entry zero always reads as zero. The second is one index register per processing element. Instructions can load, step and compare the control-unit registers, with the compare producing a loop-branch decision. Another instruction fills the per-element registers with a strided pattern, which gives skewed storage layouts. Address outputs are combinational from the current instruction and the registered state. Register updates become visible after the next rising clock edge.

Top module: `simd_agu`

## Requirements
- R1: After reset, every control-unit index register and every per-element index register holds zero.
- R2: Control-unit index register 0 always reads as zero, and a load or increment that names register 0 has no effect.
- R3: Opcode 2 (load immediate) with in_valid=1 writes in_adr into register in_ix. The new value is visible from the next clock edge.
- R4: Opcode 3 (increment) with in_valid=1 adds in_adr to register in_ix, modulo 2^ADDR_W, at the next clock edge.
- R5: cu_addr equals (in_adr + X[in_ix]) mod 2^ADDR_W. It never includes a per-element index, whatever the value of in_psel.
- R6: cu_bank equals the low log2(NUM_PE) bits of cu_addr, and cu_word equals the remaining upper bits.
- R7: pe_addr carries element k in bits [k*LOC_W +: LOC_W], where LOC_W = ADDR_W - log2(NUM_PE). That field equals (in_adr + X[in_ix] + (in_psel ? P[k] : 0)) mod 2^LOC_W.
- R8: Opcode 5 (set element index) with in_valid=1 loads each P[k] with (in_adr + k*X[in_ix]) mod 2^LOC_W at the next clock edge.
- R9: br_taken is 1 exactly when in_valid=1, the opcode is 4 (compare), and X[in_ix] < X[in_ix2] unsigned. A compare changes no register.
- R10: When in_valid=0, or the opcode is 0, 1, 6 or 7, no register changes and br_taken is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 3 | Opcode |
| in_psel | input | 1 | Add the per-element index into element addresses |
| in_ix | input | IX_W | Primary control-unit index register number |
| in_ix2 | input | IX_W | Second register number (compare limit) |
| in_adr | input | ADDR_W | Address / immediate field |
| cu_addr | output | ADDR_W | Flat control-unit address |
| cu_bank | output | log2(NUM_PE) | Bank select part of cu_addr |
| cu_word | output | LOC_W | Word-in-bank part of cu_addr |
| pe_addr | output | NUM_PE*LOC_W | Local address of every element |
| br_taken | output | 1 | Compare-and-branch decision |

## Verification
A corrupted control-unit index register shows up at the ports as soon as an instruction names that register. It appears as an offset error in cu_addr and in every element address, or as a wrong branch decision. A corrupted per-element index appears only in that element's slice of pe_addr, and only when in_psel=1. The bench therefore addresses through every register after each update, in the cycle right after the update edge, with in_psel set both ways. A lost or misdirected write is then caught within one or two instructions.

// File: rtl/simd_agu_pkg.sv
package simd_agu_pkg;
    typedef enum logic [2:0] {
        OP_ADDR  = 3'd0,
        OP_LDI   = 3'd2,
        OP_INC   = 3'd3,
        OP_CMPB  = 3'd4,
        OP_SETPE = 3'd5
    } agu_op_e;
endpackage

// File: rtl/agu_cu_regs.sv
module agu_cu_regs #(
    parameter int NREG   = 8,
    parameter int ADDR_W = 12,
    localparam int IX_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IX_W-1:0]   wr_ix,
    input  logic [ADDR_W-1:0] wr_val,
    input  logic [IX_W-1:0]   rd_ix_a,
    input  logic [IX_W-1:0]   rd_ix_b,
    output logic [ADDR_W-1:0] rd_a,
    output logic [ADDR_W-1:0] rd_b
);
    typedef struct packed {
        logic [NREG-1:0][ADDR_W-1:0] x;
    } cu_state_t;

    cu_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && wr_ix != '0)
            st_d.x[wr_ix] = wr_val;
        st_d.x[0] = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_a = (rd_ix_a == '0) ? '0 : st_q.x[rd_ix_a];
    assign rd_b = (rd_ix_b == '0) ? '0 : st_q.x[rd_ix_b];

    // R2: a write aimed at register 0 leaves the whole file untouched
    a_r2_zero_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ix == '0) |=> $stable(st_q.x));

    // R10: no write request, no change
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.x));

    // R3 / R4: a write to a nonzero register is readable one edge later
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ix != '0) |=> (st_q.x[$past(wr_ix)] == $past(wr_val)));
endmodule

// File: rtl/agu_pe_regs.sv
module agu_pe_regs #(
    parameter int NUM_PE = 4,
    parameter int ADDR_W = 12,
    localparam int M     = $clog2(NUM_PE),
    localparam int LOC_W = ADDR_W - M
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    set_en,
    input  logic [LOC_W-1:0]        base,
    input  logic [ADDR_W-1:0]       stride,
    output logic [NUM_PE*LOC_W-1:0] idx_flat
);
    typedef struct packed {
        logic [NUM_PE-1:0][LOC_W-1:0] p;
    } pe_state_t;

    pe_state_t st_d, st_q;
    logic [NUM_PE-1:0][LOC_W-1:0] fill;

    for (genvar k = 0; k < NUM_PE; k++) begin : g_fill
        assign fill[k] = base + LOC_W'(k) * stride[LOC_W-1:0];
        assign idx_flat[k*LOC_W +: LOC_W] = st_q.p[k];
    end

    always_comb begin
        st_d = st_q;
        if (set_en)
            st_d.p = fill;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8 / R10: element indices move only on a set request
    a_r8_hold_unless_set: assert property (@(posedge clk) disable iff (!rst_n)
        !set_en |=> $stable(st_q.p));

    // R8: element 0 receives the base alone
    a_r8_elem0_base: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> (st_q.p[0] == $past(base)));
endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc #(
    parameter int NUM_PE = 4,
    parameter int ADDR_W = 12,
    localparam int M     = $clog2(NUM_PE),
    localparam int LOC_W = ADDR_W - M
) (
    input  logic [ADDR_W-1:0]       adr,
    input  logic [ADDR_W-1:0]       cu_idx,
    input  logic                    psel,
    input  logic [NUM_PE*LOC_W-1:0] pe_idx_flat,
    output logic [ADDR_W-1:0]       cu_addr,
    output logic [NUM_PE*LOC_W-1:0] pe_addr_flat
);
    logic [ADDR_W-1:0] base_sum;

    assign base_sum = adr + cu_idx;
    assign cu_addr  = base_sum;

    for (genvar k = 0; k < NUM_PE; k++) begin : g_pe
        logic [LOC_W-1:0] own;
        assign own = psel ? pe_idx_flat[k*LOC_W +: LOC_W] : '0;
        assign pe_addr_flat[k*LOC_W +: LOC_W] = base_sum[LOC_W-1:0] + own;
    end
endmodule

// File: rtl/simd_agu.sv
module simd_agu
    import simd_agu_pkg::*;
#(
    parameter int NUM_PE = 4,
    parameter int ADDR_W = 12,
    parameter int NREG   = 8,
    localparam int M     = $clog2(NUM_PE),
    localparam int LOC_W = ADDR_W - M,
    localparam int IX_W  = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [2:0]              in_op,
    input  logic                    in_psel,
    input  logic [IX_W-1:0]         in_ix,
    input  logic [IX_W-1:0]         in_ix2,
    input  logic [ADDR_W-1:0]       in_adr,
    output logic [ADDR_W-1:0]       cu_addr,
    output logic [M-1:0]            cu_bank,
    output logic [LOC_W-1:0]        cu_word,
    output logic [NUM_PE*LOC_W-1:0] pe_addr,
    output logic                    br_taken
);
    logic [ADDR_W-1:0]       xa, xb, wr_val;
    logic                    wr_en, set_en;
    logic [NUM_PE*LOC_W-1:0] pe_idx;

    always_comb begin
        wr_en  = in_valid && (in_op == OP_LDI || in_op == OP_INC);
        wr_val = (in_op == OP_INC) ? (xa + in_adr) : in_adr;
        set_en = in_valid && (in_op == OP_SETPE);
    end

    agu_cu_regs #(.NREG(NREG), .ADDR_W(ADDR_W)) u_cu (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ix(in_ix), .wr_val(wr_val),
        .rd_ix_a(in_ix), .rd_ix_b(in_ix2), .rd_a(xa), .rd_b(xb)
    );

    agu_pe_regs #(.NUM_PE(NUM_PE), .ADDR_W(ADDR_W)) u_pe (
        .clk(clk), .rst_n(rst_n), .set_en(set_en), .base(in_adr[LOC_W-1:0]),
        .stride(xa), .idx_flat(pe_idx)
    );

    agu_addr_calc #(.NUM_PE(NUM_PE), .ADDR_W(ADDR_W)) u_calc (
        .adr(in_adr), .cu_idx(xa), .psel(in_psel), .pe_idx_flat(pe_idx),
        .cu_addr(cu_addr), .pe_addr_flat(pe_addr)
    );

    assign cu_bank  = cu_addr[M-1:0];
    assign cu_word  = cu_addr[ADDR_W-1:M];
    assign br_taken = in_valid && (in_op == OP_CMPB) && (xa < xb);

    // R9: a branch decision comes only from a valid compare
    a_r9_branch_source: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> (in_valid && in_op == OP_CMPB));

    // R9: compare leaves the flat address of the same register unchanged next cycle
    a_r9_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_CMPB) |=> (u_cu.rd_a == $past(xa) || in_ix != $past(in_ix)));

    // R6: bank and word fields rebuild the flat address
    a_r6_split: assert property (@(posedge clk) disable iff (!rst_n)
        {cu_word, cu_bank} == cu_addr);

    // R5 / R7: with no element index, element 0 sees the low part of the flat address
    a_r7_elem0_plain: assert property (@(posedge clk) disable iff (!rst_n)
        !in_psel |-> (pe_addr[LOC_W-1:0] == cu_addr[LOC_W-1:0]));
endmodule

// File: tb/simd_agu_test.sv
module simd_agu_test;
    localparam int NUM_PE = 4;
    localparam int ADDR_W = 12;
    localparam int NREG   = 8;
    localparam int M      = 2;
    localparam int LOC_W  = 10;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid, in_psel;
    logic [2:0] in_op, in_ix, in_ix2;
    logic [ADDR_W-1:0] in_adr;
    logic [ADDR_W-1:0] cu_addr;
    logic [M-1:0] cu_bank;
    logic [LOC_W-1:0] cu_word;
    logic [NUM_PE*LOC_W-1:0] pe_addr;
    logic br_taken;

    int checks = 0;
    int fails  = 0;
    logic [ADDR_W-1:0] xm [NREG];
    logic [LOC_W-1:0]  pm [NUM_PE];
    logic [ADDR_W-1:0] seen_cu;
    logic [LOC_W-1:0]  seen_pe [NUM_PE];
    logic              seen_br;

    always #10 clk = ~clk;

    simd_agu uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_psel(in_psel), .in_ix(in_ix), .in_ix2(in_ix2), .in_adr(in_adr),
        .cu_addr(cu_addr), .cu_bank(cu_bank), .cu_word(cu_word),
        .pe_addr(pe_addr), .br_taken(br_taken)
    );

    function automatic logic [ADDR_W-1:0] rx(input logic [2:0] ix);
        return (ix == 3'd0) ? '0 : xm[ix];
    endfunction

    function automatic logic [ADDR_W-1:0] exp_cu(input logic [2:0] ix, input logic [ADDR_W-1:0] adr);
        return adr + rx(ix);
    endfunction

    function automatic logic [LOC_W-1:0] exp_pe(input int k, input logic [2:0] ix,
                                                input logic [ADDR_W-1:0] adr, input logic ps);
        logic [ADDR_W-1:0] s;
        s = adr + rx(ix);
        return s[LOC_W-1:0] + (ps ? pm[k] : '0);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [2:0] op, input logic ps,
                        input logic [2:0] ix, input logic [2:0] ix2, input logic [ADDR_W-1:0] adr);
        logic [ADDR_W-1:0] ecu;
        @(negedge clk);
        in_valid = v; in_op = op; in_psel = ps; in_ix = ix; in_ix2 = ix2; in_adr = adr;
        #2;
        ecu = exp_cu(ix, adr);
        chk("R5 cu_addr", 32'(cu_addr), 32'(ecu));
        chk("R6 cu_bank", 32'(cu_bank), 32'(ecu[M-1:0]));
        chk("R6 cu_word", 32'(cu_word), 32'(ecu[ADDR_W-1:M]));
        for (int k = 0; k < NUM_PE; k++)
            chk("R7 pe_addr", 32'(pe_addr[k*LOC_W +: LOC_W]), 32'(exp_pe(k, ix, adr, ps)));
        chk("R9 br_taken", 32'(br_taken), 32'(v && op == 3'd4 && rx(ix) < rx(ix2)));
        seen_cu = cu_addr;
        seen_br = br_taken;
        for (int k = 0; k < NUM_PE; k++) seen_pe[k] = pe_addr[k*LOC_W +: LOC_W];
        @(posedge clk);
        if (v) begin
            if (op == 3'd2 && ix != 0) xm[ix] = adr;
            else if (op == 3'd3 && ix != 0) xm[ix] = xm[ix] + adr;
            else if (op == 3'd5)
                for (int k = 0; k < NUM_PE; k++) pm[k] = adr[LOC_W-1:0] + LOC_W'(k) * rx(ix)[LOC_W-1:0];
        end
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd12345));
        for (int i = 0; i < NREG; i++) xm[i] = '0;
        for (int k = 0; k < NUM_PE; k++) pm[k] = '0;
        rst_n = 1'b0; in_valid = 0; in_op = 0; in_psel = 0; in_ix = 0; in_ix2 = 0; in_adr = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: every register reads zero after reset
        for (int r = 0; r < NREG; r++) begin
            step(1'b1, 3'd0, 1'b1, 3'(r), 3'd0, '0);
            chk("R1 reset cu", 32'(seen_cu), 32'd0);
            chk("R1 reset pe", 32'(seen_pe[NUM_PE-1]), 32'd0);
        end

        // R2: writes to register 0 are dropped
        step(1'b1, 3'd2, 1'b0, 3'd0, 3'd0, 12'h555);
        step(1'b1, 3'd3, 1'b0, 3'd0, 3'd0, 12'h0aa);
        step(1'b1, 3'd0, 1'b0, 3'd0, 3'd0, 12'h001);
        chk("R2 reg0 zero", 32'(seen_cu), 32'h001);

        // R3: load immediate visible next cycle
        step(1'b1, 3'd2, 1'b0, 3'd3, 3'd0, 12'h123);
        step(1'b1, 3'd0, 1'b0, 3'd3, 3'd0, 12'h000);
        chk("R3 ldi", 32'(seen_cu), 32'h123);

        // R4: increment wraps at 2^ADDR_W
        step(1'b1, 3'd2, 1'b0, 3'd5, 3'd0, 12'hffe);
        step(1'b1, 3'd3, 1'b0, 3'd5, 3'd0, 12'h005);
        step(1'b1, 3'd0, 1'b0, 3'd5, 3'd0, 12'h000);
        chk("R4 inc wrap", 32'(seen_cu), 32'h003);

        // R9: equal, less, greater compares
        step(1'b1, 3'd2, 1'b0, 3'd1, 3'd0, 12'h010);
        step(1'b1, 3'd2, 1'b0, 3'd2, 3'd0, 12'h010);
        step(1'b1, 3'd4, 1'b0, 3'd1, 3'd2, 12'h000);
        chk("R9 equal not taken", 32'(seen_br), 32'd0);
        step(1'b1, 3'd3, 1'b0, 3'd2, 3'd0, 12'h001);
        step(1'b1, 3'd4, 1'b0, 3'd1, 3'd2, 12'h000);
        chk("R9 less taken", 32'(seen_br), 32'd1);
        step(1'b1, 3'd4, 1'b0, 3'd2, 3'd1, 12'h000);
        chk("R9 greater not taken", 32'(seen_br), 32'd0);

        // R8: strided fill, then per-element addressing with psel (R5 ignores it)
        step(1'b1, 3'd5, 1'b0, 3'd1, 3'd0, 12'h100);
        step(1'b1, 3'd0, 1'b1, 3'd0, 3'd0, 12'h000);
        chk("R8 elem3", 32'(seen_pe[3]), 32'h130);
        chk("R5 cu ignores psel", 32'(seen_cu), 32'h000);

        // R10: invalid instruction and spare opcodes change nothing
        step(1'b0, 3'd2, 1'b0, 3'd3, 3'd0, 12'h777);
        step(1'b1, 3'd7, 1'b0, 3'd3, 3'd0, 12'h777);
        step(1'b0, 3'd5, 1'b0, 3'd1, 3'd0, 12'h3ff);
        step(1'b1, 3'd0, 1'b1, 3'd3, 3'd0, 12'h000);
        chk("R10 cu kept", 32'(seen_cu), 32'h123);
        chk("R10 pe kept", 32'(seen_pe[1]), 32'(12'h123 + 12'h110));

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic v;
            v = ($urandom % 10) != 0;
            step(v, 3'($urandom), 1'($urandom), 3'($urandom), 3'($urandom), 12'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule